// File: doc/BRIEF.md
# Command-Word Guarded Watchdog Timer

This block is a bus-attached watchdog built around a 20-bit down-counter that steps once per pulse of a slow timebase enable. Software controls it by writing 16-bit command words to one control register. The command words stop the counter, restart it, acknowledge the expiry flag, open or close the reload window, and refill the counter to its ceiling. Any other word written there does nothing.

The count register shows the upper sixteen bits of the counter. A reload through this register takes effect only while the window is open. When a running counter steps from one to zero, the block latches a sticky expiry flag, gives a one-cycle reset request, and stays at zero until software reloads it. To force a prompt restart, software opens the window, loads a count of one, closes the window and resumes. The request then follows sixteen timebase pulses later.

Top module: `wdog_magic_top`

## Requirements
- R1: After the synchronous active-high reset, the block is halted and the reload window is closed. The counter holds 0xFFFF0, so a read of the count register gives 0xFFFF. The expiry flag and the reset request are both low.
- R2: Writing 0x3877 to the control register (offset 0x0) halts the counter, and timebase pulses then leave it unchanged. Writing 0x4A4B restarts it. While running, the counter drops by exactly one on each timebase pulse until it reaches zero.
- R3: While the reload window is closed, writes to the count register (offset 0x4) leave the counter unchanged.
- R4: Writing 0xAB00 to the control register opens the reload window, and writing 0xAB01 closes it. While the window is open, a count-register write loads bits [15:0] of the write data into counter bits [19:4] and clears counter bits [3:0]. Bits [31:16] of the write data are ignored.
- R5: The read data is combinational from the address. Offset 0x4 returns counter bits [19:4] in bits [15:0] and zeros above them. Offset 0x0 returns zero.
- R6: Writing 0xDEAF to the control register loads 0xFFFF0 into the counter whether the window is open or closed.
- R7: When the counter steps from 1 to 0 while running, the reset request goes high for exactly one clock cycle, starting right after that edge. The expiry flag is set at the same edge, and the counter then stays at zero.
- R8: Writing 0x7482 to the control register clears the expiry flag.
- R9: Writing any other value to the control register changes nothing: not the running state, the window, the flag, nor the counter. Only bits [15:0] of a control write are compared.
- R10: If software loads a count of 1 and then resumes, the reset request comes on the 16th timebase pulse and on no earlier pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timebase enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Directed sequences come first. They cover the halted counter under pulses, count writes with the window closed and with it open, and write data with high bits set to show that only the low half loads. They also cover junk control words, a refill with the window closed, and the restart sequence, counted pulse by pulse up to the expiry edge and past it. After that, a seeded random mix of commands, small reloads and pulse bursts is compared against a bench model. Small reloads make expiries frequent, so the random phase separates a counter that misses the 1-to-0 step from one that fires early, repeats the request, or keeps counting below zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CMD_W = 16;

    localparam logic [CMD_W-1:0] K_HALT = 16'h3877;
    localparam logic [CMD_W-1:0] K_RUN  = 16'h4A4B;
    localparam logic [CMD_W-1:0] K_ACK  = 16'h7482;
    localparam logic [CMD_W-1:0] K_OPEN = 16'hAB00;
    localparam logic [CMD_W-1:0] K_SEAL = 16'hAB01;
    localparam logic [CMD_W-1:0] K_FILL = 16'hDEAF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_HALT,
        OP_RUN,
        OP_ACK,
        OP_OPEN,
        OP_SEAL,
        OP_FILL
    } wd_op_e;

    typedef struct packed {
        wd_op_e op;
        logic   cnt_wr;
    } wd_req_t;

    function automatic wd_op_e decode_word(input logic [CMD_W-1:0] w);
        wd_op_e r;
        case (w)
            K_HALT:  r = OP_HALT;
            K_RUN:   r = OP_RUN;
            K_ACK:   r = OP_ACK;
            K_OPEN:  r = OP_OPEN;
            K_SEAL:  r = OP_SEAL;
            K_FILL:  r = OP_FILL;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdog_cmd_dec.sv
module wdog_cmd_dec
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 'h4
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wd_req_t           req
);

    always_comb begin
        req.op     = OP_NONE;
        req.cnt_wr = 1'b0;
        if (we && addr == CTRL_OFS) begin
            req.op = decode_word(wdata[CMD_W-1:0]);
        end
        if (we && addr == CNT_OFS) begin
            req.cnt_wr = 1'b1;
        end
    end

endmodule

// File: rtl/wdog_ctrl_state.sv
module wdog_ctrl_state
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wd_op_e op,
    input  logic   expire,
    output logic   running,
    output logic   unlocked,
    output logic   irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            unlocked <= 1'b0;
            irq      <= 1'b0;
        end else begin
            case (op)
                OP_HALT: running  <= 1'b0;
                OP_RUN:  running  <= 1'b1;
                OP_OPEN: unlocked <= 1'b1;
                OP_SEAL: unlocked <= 1'b0;
                default: ;
            endcase
            if (expire) begin
                irq <= 1'b1;
            end else if (op == OP_ACK) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdog_dcnt.sv
module wdog_dcnt #(
    parameter int CNT_W  = 20,
    parameter int FRAC_W = 4,
    localparam int REG_W = CNT_W - FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             running,
    input  logic             fill,
    input  logic             ld,
    input  logic [REG_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             rst_req
);

    localparam logic [CNT_W-1:0] CNT_MAX = {{REG_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic step;

    assign step   = running && tick && (cnt != '0) && !fill && !ld;
    assign expire = step && (cnt == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CNT_MAX;
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire;
            if (fill) begin
                cnt <= CNT_MAX;
            end else if (ld) begin
                cnt <= {ld_val, {FRAC_W{1'b0}}};
            end else if (step) begin
                cnt <= cnt - CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/wdog_magic_top.sv
module wdog_magic_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int FRAC_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam int REG_W = CNT_W - FRAC_W;

    wd_req_t          req;
    logic             running;
    logic             unlocked;
    logic             expire;
    logic             fill;
    logic             ld;
    logic             ack;
    logic [CNT_W-1:0] cnt;

    wdog_cmd_dec #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CTRL_OFS(CTRL_OFS),
        .CNT_OFS (CNT_OFS)
    ) u_dec (
        .we   (bus_we),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .req  (req)
    );

    wdog_ctrl_state u_state (
        .clk     (clk),
        .rst     (rst),
        .op      (req.op),
        .expire  (expire),
        .running (running),
        .unlocked(unlocked),
        .irq     (irq)
    );

    assign fill = (req.op == OP_FILL);
    assign ack  = (req.op == OP_ACK);
    assign ld   = req.cnt_wr && unlocked;

    wdog_dcnt #(
        .CNT_W (CNT_W),
        .FRAC_W(FRAC_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .running(running),
        .fill   (fill),
        .ld     (ld),
        .ld_val (bus_wdata[REG_W-1:0]),
        .cnt    (cnt),
        .expire (expire),
        .rst_req(rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CNT_OFS) begin
            bus_rdata[REG_W-1:0] = cnt[CNT_W-1:FRAC_W];
        end
    end

endmodule

// File: rtl/wdog_magic_chk.sv
module wdog_magic_chk #(
    parameter int CNT_W  = 20,
    parameter int FRAC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             running,
    input logic             unlocked,
    input logic             fill,
    input logic             ld,
    input logic             ack,
    input logic             expire,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             rst_req
);

    localparam int REG_W = CNT_W - FRAC_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {{REG_W{1'b1}}, {FRAC_W{1'b0}}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt == CNT_MAX && !irq && !rst_req && !running && !unlocked));

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7
    pulse_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (cnt == '0 && irq));

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !fill && !ld) |=> $stable(cnt));

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !fill && !(running && tick)) |=> $stable(cnt));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (running && tick && !fill && !ld && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !expire) |=> !irq);

endmodule

bind wdog_magic_top wdog_magic_chk #(
    .CNT_W (CNT_W),
    .FRAC_W(FRAC_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .running (running),
    .unlocked(unlocked),
    .fill    (fill),
    .ld      (ld),
    .ack     (ack),
    .expire  (expire),
    .cnt     (cnt),
    .irq     (irq),
    .rst_req (rst_req)
);

// File: tb/sim_wdog_magic_top.sv
`timescale 1ns/1ps
module sim_wdog_magic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    logic [19:0] m_cnt;
    logic        m_run, m_unl, m_irq;

    always #2.5 clk = ~clk;

    wdog_magic_top u0 (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit is_magic(input logic [15:0] w);
        return w == 16'h3877 || w == 16'h4A4B || w == 16'h7482 ||
               w == 16'hAB00 || w == 16'hAB01 || w == 16'hDEAF;
    endfunction

    function automatic logic [31:0] exp_read();
        return {16'h0, m_cnt[19:4]};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 4'h0) begin
            case (d[15:0])
                16'h3877: m_run = 1'b0;
                16'h4A4B: m_run = 1'b1;
                16'h7482: m_irq = 1'b0;
                16'hAB00: m_unl = 1'b1;
                16'hAB01: m_unl = 1'b0;
                16'hDEAF: m_cnt = 20'hFFFF0;
                default: ;
            endcase
        end else if (a == 4'h4 && m_unl) begin
            m_cnt = {d[15:0], 4'h0};
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_tick(input string tag);
        bit pulse;
        pulse = 1'b0;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (m_run && m_cnt != 0) begin
            pulse = (m_cnt == 20'd1);
            m_cnt = m_cnt - 20'd1;
            if (pulse) m_irq = 1'b1;
        end
        chk({tag, " rst_req"}, {31'b0, rst_req}, {31'b0, pulse});
    endtask

    task automatic chk_state(input string tag);
        logic [31:0] v;
        rd(4'h4, v);
        chk({tag, " count"}, v, exp_read());
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2718));
        m_cnt = 20'hFFFF0; m_run = 0; m_unl = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_state("R1 reset");
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        for (int i = 0; i < 5; i++) do_tick("R1 halted");
        chk_state("R1 halted after ticks");
        // R3 locked after reset
        wr(4'h4, 32'h0000_1234);
        chk_state("R3 locked write");
        // R5 control offset reads zero
        rd(4'h0, v);
        chk("R5 ctrl read", v, 32'h0);

        // R4 open window and load
        wr(4'h0, 32'h0000_AB00);
        wr(4'h4, 32'h0000_0003);
        rd(4'h4, v);
        chk("R4 load", v, 32'h0000_0003);
        wr(4'h4, 32'hABCD_0005);
        rd(4'h4, v);
        chk("R4 high bits ignored", v, 32'h0000_0005);
        wr(4'h0, 32'h0000_AB01);
        wr(4'h4, 32'h0000_0007);
        chk_state("R3 after seal");

        // R2 halt and run
        for (int i = 0; i < 3; i++) do_tick("R2 halted");
        chk_state("R2 halted");
        wr(4'h0, 32'h0000_4A4B);
        for (int i = 0; i < 16; i++) do_tick("R2 run");
        rd(4'h4, v);
        chk("R2 sixteen steps", v, 32'h0000_0004);
        wr(4'h0, 32'h0000_3877);
        for (int i = 0; i < 16; i++) do_tick("R2 stop");
        rd(4'h4, v);
        chk("R2 stopped", v, 32'h0000_0004);

        // R9 junk control words
        wr(4'h0, 32'h0000_1234);
        wr(4'h0, 32'h0000_AB02);
        wr(4'h0, 32'h4A4B_0000);
        wr(4'h4, 32'h0000_0009);
        do_tick("R9 junk");
        chk_state("R9 junk");

        // R6 fill with window closed
        wr(4'h0, 32'h0000_DEAF);
        rd(4'h4, v);
        chk("R6 fill", v, 32'h0000_FFFF);

        // R10 forced restart sequence
        wr(4'h0, 32'h0000_AB00);
        wr(4'h4, 32'h0000_0001);
        wr(4'h0, 32'h0000_AB01);
        wr(4'h0, 32'h0000_4A4B);
        for (int i = 0; i < 15; i++) do_tick("R10 early");
        chk("R10 irq before", {31'b0, irq}, 32'h0);
        do_tick("R10 sixteenth");
        chk("R7 irq set", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R7 single pulse", {31'b0, rst_req}, 32'h0);
        for (int i = 0; i < 4; i++) do_tick("R7 held");
        rd(4'h4, v);
        chk("R7 held zero", v, 32'h0);
        wr(4'h0, 32'h0000_5555);
        chk("R9 irq kept", {31'b0, irq}, 32'h1);
        // R8 acknowledge
        wr(4'h0, 32'h0000_7482);
        chk("R8 ack", {31'b0, irq}, 32'h0);

        // random mix against the model
        for (int it = 0; it < 400; it++) begin
            int r;
            logic [15:0] junk;
            r = $urandom % 12;
            case (r)
                0: wr(4'h0, 32'h0000_3877);
                1, 2: wr(4'h0, 32'h0000_4A4B);
                3: wr(4'h0, 32'h0000_7482);
                4: wr(4'h0, 32'h0000_AB00);
                5: wr(4'h0, 32'h0000_AB01);
                6: if ($urandom % 4 == 0) wr(4'h0, 32'h0000_DEAF);
                7: wr(4'h4, {$urandom, 16'h0} | 32'($urandom % 4));
                8: begin
                    junk = 16'($urandom);
                    if (is_magic(junk)) junk = 16'h0000;
                    wr(4'h0, {16'($urandom), junk});
                end
                default: begin
                    int n;
                    n = 1 + ($urandom % 40);
                    for (int k = 0; k < n; k++) do_tick("R7 random tick");
                end
            endcase
            chk_state("R2 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule